// File: doc/BRIEF.md
# Segment Descriptor Cache Loader

This block refreshes the hidden descriptor copy that sits behind one segment register. When a new 16-bit selector is offered, the loader splits it into a table index, a table choice and a requested privilege level. It picks the global or local table base and limit, checks that the whole 8-byte entry lies inside that table, and fetches the entry as two 32-bit reads. The entry is then validated. If its accessed flag is still clear, the loader writes the flag back to memory. Only after that does it commit base, limit, access byte and flags to the cache.

The loader is a single sequencer. It accepts a selector with a valid/ready handshake and talks to memory through a request/acknowledge port that holds its request until the acknowledge arrives. Every load ends with a one-cycle `done`. When the load was refused, `fault` is high in that same cycle and the cache keeps what it held before. A selector equal to the one already cached is acknowledged without touching memory.

Top module: `seg_desc_loader`

## Requirements
- R1: The selector is split as index = bits 15..3, table choice = bit 2 (0 global, 1 local), requested level = bits 1..0. The entry is read at table base + index*8 and then at table base + index*8 + 4.
- R2: The cached base, access byte and flags are assembled from the two words. The low word gives limit[15:0] in bits 15..0 and base[15:0] in bits 31..16. The high word gives base[23:16] in bits 7..0, the access byte in bits 15..8, limit[19:16] in bits 19..16, the flags in bits 23..20 (granularity is bit 23) and base[31:24] in bits 31..24.
- R3: With granularity clear the cached limit is the 20-bit field zero-extended. With granularity set it is the field shifted left by 12 with the low 12 bits filled with ones.
- R4: A global-table selector with index 0 faults without any memory access. Index 0 of the local table loads normally.
- R5: If index*8+7 exceeds the chosen table's limit, the load faults before any memory request. An entry ending exactly at the limit is accepted.
- R6: An entry whose present bit (access bit 7) is 0 faults, and the cache contents stay unchanged.
- R7: The load faults when the requested level is numerically greater than the entry's privilege field (access bits 6..5).
- R8: If access bit 0 (accessed) is clear, the high word is written back to base + index*8 + 4 with bit 8 set, before commit. If the bit is already set, no write is issued. The cached access byte always has bit 0 set.
- R9: A selector equal to the currently valid cached selector completes without a fault and without any memory access.
- R10: `done` lasts one cycle, `fault` is only high together with `done`, `sel_ready` is low while a load is in progress, and a memory request holds its address until acknowledged.
- R11: After reset the cache is invalid, `sel_ready` is high, and `done`, `fault` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_valid | input | 1 | New selector offered |
| sel_in | input | 16 | Selector value |
| sel_ready | output | 1 | Loader idle, selector accepted when valid |
| gdt_base | input | 32 | Global table base address |
| gdt_limit | input | 32 | Global table byte limit |
| ldt_base | input | 32 | Local table base address |
| ldt_limit | input | 32 | Local table byte limit |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with acknowledge |
| mem_ack | input | 1 | Request completed this cycle |
| cache_sel | output | 16 | Selector held in cache |
| cache_base | output | 32 | Cached segment base |
| cache_limit | output | 32 | Cached byte limit after granularity expansion |
| cache_ar | output | 8 | Cached access byte |
| cache_flags | output | 4 | Cached flag nibble |
| cache_valid | output | 1 | Cache holds a committed entry |
| done | output | 1 | Load finished (one cycle) |
| fault | output | 1 | Load refused, with done |

## Verification
The hardest case to reach from the ports is a refusal that comes after both reads have completed, where the cache must still hold the previous segment. The stimulus first commits one segment. It then loads entries that are not present or that sit at too high a privilege for the requested level. The bench confirms that two reads occurred and that every cache field still matches the earlier commit. The write-back is reached by placing entries with a clear accessed bit at a table's exact upper edge, which covers the limit boundary and the read-modify-write in one load.

// File: rtl/seg_desc_loader.sv
module seg_desc_loader (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel_valid,
  input  logic [15:0] sel_in,
  output logic        sel_ready,
  input  logic [31:0] gdt_base,
  input  logic [31:0] gdt_limit,
  input  logic [31:0] ldt_base,
  input  logic [31:0] ldt_limit,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ack,
  output logic [15:0] cache_sel,
  output logic [31:0] cache_base,
  output logic [31:0] cache_limit,
  output logic [7:0]  cache_ar,
  output logic [3:0]  cache_flags,
  output logic        cache_valid,
  output logic        done,
  output logic        fault
);

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_RD_LO, S_RD_HI, S_VALID, S_WR_AR, S_COMMIT
  } state_t;

  state_t      state;
  logic [15:0] sel_q;
  logic [31:0] lo_q, hi_q;

  logic [12:0] idx;
  logic        ti;
  logic [1:0]  rpl;
  logic [31:0] tbl_base, tbl_limit, desc_addr, span_end;
  logic [7:0]  ar;
  logic [19:0] raw_lim;
  logic        is_null, hit, xfer, deny;

  assign idx       = sel_q[15:3];
  assign ti        = sel_q[2];
  assign rpl       = sel_q[1:0];
  assign tbl_base  = ti ? ldt_base : gdt_base;
  assign tbl_limit = ti ? ldt_limit : gdt_limit;
  assign desc_addr = tbl_base + {16'b0, idx, 3'b000};
  assign span_end  = {16'b0, idx, 3'b111};
  assign is_null   = !ti && (idx == 13'd0);
  assign hit       = cache_valid && (sel_q == cache_sel);

  assign ar        = hi_q[15:8];
  assign raw_lim   = {hi_q[19:16], lo_q[15:0]};
  assign deny      = !ar[7] || (rpl > ar[6:5]);

  assign sel_ready = (state == S_IDLE);
  assign mem_req   = (state == S_RD_LO) || (state == S_RD_HI) || (state == S_WR_AR);
  assign mem_we    = (state == S_WR_AR);
  assign mem_addr  = (state == S_RD_LO) ? desc_addr : desc_addr + 32'd4;
  assign mem_wdata = hi_q | 32'h0000_0100;
  assign xfer      = mem_req && mem_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      sel_q       <= '0;
      lo_q        <= '0;
      hi_q        <= '0;
      cache_sel   <= '0;
      cache_base  <= '0;
      cache_limit <= '0;
      cache_ar    <= '0;
      cache_flags <= '0;
      cache_valid <= 1'b0;
      done        <= 1'b0;
      fault       <= 1'b0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      case (state)
        S_IDLE:
          if (sel_valid) begin
            sel_q <= sel_in;
            state <= S_CHECK;
          end
        S_CHECK:
          if (hit) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else if (is_null || (span_end > tbl_limit)) begin
            done  <= 1'b1;
            fault <= 1'b1;
            state <= S_IDLE;
          end else begin
            state <= S_RD_LO;
          end
        S_RD_LO:
          if (xfer) begin
            lo_q  <= mem_rdata;
            state <= S_RD_HI;
          end
        S_RD_HI:
          if (xfer) begin
            hi_q  <= mem_rdata;
            state <= S_VALID;
          end
        S_VALID:
          if (deny) begin
            done  <= 1'b1;
            fault <= 1'b1;
            state <= S_IDLE;
          end else begin
            state <= ar[0] ? S_COMMIT : S_WR_AR;
          end
        S_WR_AR:
          if (xfer) state <= S_COMMIT;
        S_COMMIT: begin
          cache_sel   <= sel_q;
          cache_base  <= {hi_q[31:24], hi_q[7:0], lo_q[31:16]};
          cache_limit <= hi_q[23] ? {raw_lim, 12'hFFF} : {12'b0, raw_lim};
          cache_ar    <= ar | 8'h01;
          cache_flags <= hi_q[23:20];
          cache_valid <= 1'b1;
          done        <= 1'b1;
          state       <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_fault_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> done);

  a_r10_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  a_r10_idle_no_request: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ready |-> !mem_req);

  a_r6_fault_keeps_cache: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> ($stable(cache_base) && $stable(cache_limit) && $stable(cache_ar)
               && $stable(cache_sel) && $stable(cache_valid)));

  a_r8_write_sets_accessed: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_wdata[8]);

  a_r8_commit_accessed: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault) |-> (cache_valid && cache_ar[0] && cache_ar[7]));

  a_r7_level_respected: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault) |-> (cache_sel[1:0] <= cache_ar[6:5]));

endmodule

// File: tb/sim_seg_desc_loader.sv
module sim_seg_desc_loader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_valid = 1'b0;
  logic [15:0] sel_in = '0;
  logic        sel_ready;
  logic [31:0] gdt_base = 32'h100, gdt_limit = 32'h3F;
  logic [31:0] ldt_base = 32'h200, ldt_limit = 32'h1F;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [15:0] cache_sel;
  logic [31:0] cache_base, cache_limit;
  logic [7:0]  cache_ar;
  logic [3:0]  cache_flags;
  logic        cache_valid, done, fault;

  always #10 clk = ~clk;

  seg_desc_loader u0 (
    .clk(clk), .rst_n(rst_n), .sel_valid(sel_valid), .sel_in(sel_in), .sel_ready(sel_ready),
    .gdt_base(gdt_base), .gdt_limit(gdt_limit), .ldt_base(ldt_base), .ldt_limit(ldt_limit),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .cache_sel(cache_sel), .cache_base(cache_base),
    .cache_limit(cache_limit), .cache_ar(cache_ar), .cache_flags(cache_flags),
    .cache_valid(cache_valid), .done(done), .fault(fault));

  int total = 0, fails = 0;
  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic [31:0] mem_arr [0:255];
  logic        ack_r = 1'b0;
  logic [31:0] rdata_r = '0;
  int          rd_cnt = 0, wr_cnt = 0;
  logic [31:0] rd_prev_addr = '0, rd_last_addr = '0, wr_addr = '0, wr_data = '0;
  assign mem_ack   = ack_r;
  assign mem_rdata = rdata_r;

  always @(posedge clk) begin
    ack_r <= 1'b0;
    if (mem_req && !ack_r) begin
      ack_r <= 1'b1;
      if (mem_we) begin
        wr_cnt  <= wr_cnt + 1;
        wr_addr <= mem_addr;
        wr_data <= mem_wdata;
      end else begin
        rdata_r      <= mem_arr[mem_addr[9:2]];
        rd_cnt       <= rd_cnt + 1;
        rd_prev_addr <= rd_last_addr;
        rd_last_addr <= mem_addr;
      end
    end
  end

  function automatic logic [31:0] mk_lo(input logic [31:0] b, input logic [19:0] l);
    return {b[15:0], l[15:0]};
  endfunction
  function automatic logic [31:0] mk_hi(input logic [31:0] b, input logic [19:0] l,
                                        input logic [7:0] a, input logic [3:0] f);
    return {b[31:24], f, l[19:16], a, b[23:16]};
  endfunction
  function automatic logic [31:0] xlim(input logic [19:0] l, input logic g);
    return g ? {l, 12'hFFF} : {12'b0, l};
  endfunction

  task automatic put(input logic [31:0] addr, input logic [31:0] b, input logic [19:0] l,
                     input logic [7:0] a, input logic [3:0] f);
    mem_arr[addr[9:2]]      = mk_lo(b, l);
    mem_arr[addr[9:2] + 1]  = mk_hi(b, l, a, f);
  endtask

  typedef struct {
    logic [15:0] sel;
    logic        flt;
    logic [31:0] base, lim;
    logic [7:0]  ar;
    logic [3:0]  flg;
    logic        vld;
    int          nrd, nwr;
    logic [31:0] rda, wra, wrd;
    string       tag;
  } item_t;
  item_t sbq[$];

  logic [15:0] e_sel = '0;
  logic [31:0] e_base = '0, e_lim = '0;
  logic [7:0]  e_ar = '0;
  logic [3:0]  e_flg = '0;
  logic        e_vld = 1'b0;
  int          issued = 0, finished = 0;
  logic        busy_seen = 1'b0;

  task automatic drive(input logic [15:0] s);
    @(negedge clk);
    sel_valid = 1'b1;
    sel_in    = s;
    while (!sel_ready) @(negedge clk);
    @(negedge clk);
    sel_valid = 1'b0;
    busy_seen = !sel_ready;
    issued++;
    while (finished < issued) @(negedge clk);
  endtask

  task automatic ld_ok(input logic [15:0] s, input logic [31:0] b, input logic [19:0] l,
                       input logic [7:0] a, input logic [3:0] f, input int nrd, input int nwr,
                       input logic [31:0] rda, input string tag);
    item_t it;
    e_sel = s; e_base = b; e_lim = xlim(l, f[3]); e_ar = a | 8'h01; e_flg = f; e_vld = 1'b1;
    it.sel = e_sel; it.flt = 1'b0; it.base = e_base; it.lim = e_lim; it.ar = e_ar;
    it.flg = e_flg; it.vld = 1'b1; it.nrd = nrd; it.nwr = nwr; it.rda = rda;
    it.wra = rda + 32'd4; it.wrd = mk_hi(b, l, a, f) | 32'h100; it.tag = tag;
    sbq.push_back(it);
    drive(s);
  endtask

  task automatic ld_flt(input logic [15:0] s, input int nrd, input logic [31:0] rda, input string tag);
    item_t it;
    it.sel = e_sel; it.flt = 1'b1; it.base = e_base; it.lim = e_lim; it.ar = e_ar;
    it.flg = e_flg; it.vld = e_vld; it.nrd = nrd; it.nwr = 0; it.rda = rda;
    it.wra = '0; it.wrd = '0; it.tag = tag;
    sbq.push_back(it);
    drive(s);
  endtask

  int rd_seen = 0, wr_seen = 0;
  always @(negedge clk) begin
    if (rst_n && done) begin
      item_t it;
      int drd, dwr;
      drd = rd_cnt - rd_seen;
      dwr = wr_cnt - wr_seen;
      rd_seen = rd_cnt;
      wr_seen = wr_cnt;
      if (sbq.size() == 0) begin
        chk(1'b0, "R10 unexpected done", 32'd1, 32'd0);
      end else begin
        it = sbq.pop_front();
        chk(fault == it.flt, {it.tag, " fault"}, {31'b0, fault}, {31'b0, it.flt});
        chk(cache_sel == it.sel, {it.tag, " sel"}, {16'b0, cache_sel}, {16'b0, it.sel});
        chk(cache_base == it.base, {it.tag, " base"}, cache_base, it.base);
        chk(cache_limit == it.lim, {it.tag, " limit"}, cache_limit, it.lim);
        chk(cache_ar == it.ar, {it.tag, " ar"}, {24'b0, cache_ar}, {24'b0, it.ar});
        chk(cache_flags == it.flg, {it.tag, " flags"}, {28'b0, cache_flags}, {28'b0, it.flg});
        chk(cache_valid == it.vld, {it.tag, " valid"}, {31'b0, cache_valid}, {31'b0, it.vld});
        chk(drd == it.nrd, {it.tag, " read count"}, drd, it.nrd);
        chk(dwr == it.nwr, {it.tag, " write count (R8)"}, dwr, it.nwr);
        if (it.nrd == 2) begin
          chk(rd_prev_addr == it.rda, {it.tag, " R1 first read addr"}, rd_prev_addr, it.rda);
          chk(rd_last_addr == it.rda + 32'd4, {it.tag, " R1 second read addr"}, rd_last_addr, it.rda + 32'd4);
        end
        if (it.nwr == 1) begin
          chk(wr_addr == it.wra, {it.tag, " R8 write addr"}, wr_addr, it.wra);
          chk(wr_data == it.wrd, {it.tag, " R8 write data"}, wr_data, it.wrd);
        end
        chk(busy_seen, {it.tag, " R10 ready low while busy"}, {31'b0, busy_seen}, 32'd1);
      end
      finished++;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", 32'd0, 32'd1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem_arr[i] = '0;
    put(32'h108, 32'h0012_3456, 20'h0ABCD, 8'h93, 4'h4);
    put(32'h110, 32'hDEAD_0000, 20'h00003, 8'h92, 4'hC);
    put(32'h118, 32'h0000_5000, 20'h00FFF, 8'h12, 4'h4);
    put(32'h120, 32'h0077_0000, 20'h01234, 8'hB3, 4'h0);
    put(32'h200, 32'h0000_A000, 20'h000FF, 8'hF3, 4'h0);
    put(32'h218, 32'h0040_0000, 20'hFFFFF, 8'h92, 4'h8);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sel_ready && !done && !fault && !mem_req && !cache_valid, "R11 reset state",
        {27'b0, sel_ready, done, fault, mem_req, cache_valid}, 32'h10);

    ld_ok (16'h0008, 32'h0012_3456, 20'h0ABCD, 8'h93, 4'h4, 2, 0, 32'h108, "R1 R2 gdt idx1");
    ld_ok (16'h0008, 32'h0012_3456, 20'h0ABCD, 8'h93, 4'h4, 0, 0, 32'h0,   "R9 same selector");
    ld_ok (16'h0010, 32'hDEAD_0000, 20'h00003, 8'h92, 4'hC, 2, 1, 32'h110, "R3 R8 gran+writeback");
    ld_flt(16'h0000, 0, 32'h0,   "R4 null selector");
    ld_flt(16'h0018, 2, 32'h118, "R6 not present");
    ld_flt(16'h0023, 2, 32'h120, "R7 rpl3 over dpl1");
    ld_ok (16'h0021, 32'h0077_0000, 20'h01234, 8'hB3, 4'h0, 2, 0, 32'h120, "R7 rpl1 equal dpl1");
    ld_ok (16'h0004, 32'h0000_A000, 20'h000FF, 8'hF3, 4'h0, 2, 0, 32'h200, "R4 ldt idx0 allowed");
    ld_flt(16'h0024, 0, 32'h0,   "R5 ldt beyond limit");
    ld_flt(16'h0040, 0, 32'h0,   "R5 gdt beyond limit");
    ld_ok (16'h001C, 32'h0040_0000, 20'hFFFFF, 8'h92, 4'h8, 2, 1, 32'h218, "R5 R3 ldt at limit edge");

    repeat (2) @(negedge clk);
    chk(sbq.size() == 0, "R10 all loads completed", sbq.size(), 32'd0);
    chk(!done && !fault, "R10 done single pulse", {30'b0, done, fault}, 32'd0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule